// File: doc/BRIEF.md
# Converter Kernel Clock-Enable Prescaler

This block paces a data-converter kernel by producing a single-cycle enable pulse train on one fabric clock. Every clock in the system is modelled as a tick enable on that fabric clock. The block never generates a real clock.

The block works in one of two families of operation, chosen by a 2-bit mode field.

- **Kernel mode.** One of three kernel source ticks is picked: system clock, 16 MHz internal oscillator or PLL. Its ticks are divided by a ratio from a fixed, irregular set. This tick stream has no timing relation to the bus clock.
- **Bus-derived modes.** The bus-interface tick is divided by 1, 2 or 4. Divide-by-1 is legal only while the bus prescaler itself passes the bus clock undivided.

Any illegal setting raises a configuration-error flag and stops all enables. Any change of mode, source or ratio code restarts the count, so the next enable follows a full period of the new setting. Keeping the divided rate at or below 35 MHz is the job of the software that picks the setting.

Top module: `conv_clk_prescaler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `conv_en_o` and `cfg_err_o` are 0.
- R2: With `mode_i` = 0 (kernel mode), `psc_code_i` values 0 to 11 select division ratios 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256. Exactly one `conv_en_o` pulse occurs per N qualifying ticks. It is high in the cycle after the N-th tick.
- R3: In kernel mode, `psc_code_i` values 12 to 15 divide by 256.
- R4: In kernel mode, `src_sel_i` 0, 1, 2 picks `src_tick_i[0]` (system), `[1]` (16 MHz oscillator) or `[2]` (PLL). Ticks on the other two lines and on `bus_tick_i` are not counted.
- R5: In kernel mode, `src_sel_i` = 3 is illegal. `cfg_err_o` is 1 in the next cycle and no enable is produced.
- R6: `mode_i` values 1, 2, 3 divide `bus_tick_i` by 1, 2, 4 respectively. Kernel ticks and `psc_code_i` have no effect in these modes.
- R7: `mode_i` = 1 while `bus_psc_i` != 0 is illegal. `cfg_err_o` is 1 in the next cycle and no enable is produced. Modes 2 and 3 never flag an error on account of `bus_psc_i`.
- R8: A cycle in which `mode_i`, `src_sel_i` or `psc_code_i` differs from its value in the previous cycle clears the count, and a tick in that cycle is not counted. The next enable follows N further qualifying ticks.
- R9: Clearing an illegal setting also removes the error. A change to `bus_psc_i` alone does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 3 | Kernel source ticks: [0] system, [1] 16 MHz oscillator, [2] PLL |
| bus_tick_i | input | 1 | Bus-interface clock tick |
| src_sel_i | input | 2 | Kernel source select (3 is illegal) |
| psc_code_i | input | 4 | Kernel-mode ratio code |
| mode_i | input | 2 | 0 kernel, 1 bus/1, 2 bus/2, 3 bus/4 |
| bus_psc_i | input | 3 | Current bus prescaler setting, 0 = undivided |
| conv_en_o | output | 1 | Divided converter enable pulse |
| cfg_err_o | output | 1 | Illegal configuration flag |

## Verification
The bench walks all sixteen ratio codes and checks both the pulse count and the tick index of the first pulse.

- **Non-power-of-two ratios.** A wrong ratio table, or a counter that wraps one tick early or late, shows up at 6, 10 or 12.
- **Codes above 11.** A design that fails to saturate them at 256 shows up as a short period on those codes.
- **Unselected sources.** Ticks are driven on unselected source lines, and on the bus tick in kernel mode. A leaky multiplexer would then produce early pulses.
- **Bus divide-by-1 legality.** This mode is paired with a nonzero bus prescaler. A design that skips the legality check would pulse instead of flagging an error.
- **Ratio change mid-count.** The ratio is changed partway through a count. A design that keeps its old count would fire before the new full period.

// File: rtl/conv_clk_pkg.sv
package conv_clk_pkg;

    parameter int NUM_SRC   = 3;
    parameter int SEL_W     = 2;
    parameter int CODE_W    = 4;
    parameter int MODE_W    = 2;
    parameter int BUS_PSC_W = 3;
    parameter int CNT_W     = 8;
    localparam int RATIO_W  = CNT_W + 1;

    typedef enum logic [MODE_W-1:0] {
        MODE_KERNEL   = 2'd0,
        MODE_BUS_DIV1 = 2'd1,
        MODE_BUS_DIV2 = 2'd2,
        MODE_BUS_DIV4 = 2'd3
    } conv_mode_e;

    typedef struct packed {
        conv_mode_e        mode;
        logic [SEL_W-1:0]  sel;
        logic [CODE_W-1:0] code;
    } conv_cfg_t;

    // Kernel-mode ratio set; codes past the last entry saturate at 256.
    function automatic logic [RATIO_W-1:0] kernel_ratio(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            4'd0:    r = 9'd1;
            4'd1:    r = 9'd2;
            4'd2:    r = 9'd4;
            4'd3:    r = 9'd6;
            4'd4:    r = 9'd8;
            4'd5:    r = 9'd10;
            4'd6:    r = 9'd12;
            4'd7:    r = 9'd16;
            4'd8:    r = 9'd32;
            4'd9:    r = 9'd64;
            4'd10:   r = 9'd128;
            default: r = 9'd256;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/conv_tick_select.sv
module conv_tick_select
    import conv_clk_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int S_W   = SEL_W
) (
    input  logic [N_SRC-1:0] src_tick_i,
    input  logic             bus_tick_i,
    input  logic [S_W-1:0]   sel_i,
    input  conv_mode_e       mode_i,
    output logic             tick_o,
    output logic             sel_valid_o
);

    logic [N_SRC-1:0] hit;

    // One match lane per kernel source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_lane
        assign hit[g] = src_tick_i[g] && (sel_i == S_W'(g));
    end

    always_comb begin
        sel_valid_o = ({1'b0, sel_i} < (S_W+1)'(N_SRC));
        if (mode_i == MODE_KERNEL) begin
            tick_o = |hit;
        end else begin
            tick_o = bus_tick_i;
        end
    end

endmodule

// File: rtl/conv_ratio_decode.sv
module conv_ratio_decode
    import conv_clk_pkg::*;
(
    input  conv_mode_e               mode_i,
    input  logic [CODE_W-1:0]        code_i,
    input  logic                     sel_valid_i,
    input  logic [BUS_PSC_W-1:0]     bus_psc_i,
    output logic [RATIO_W-1:0]       ratio_o,
    output logic                     illegal_o
);

    always_comb begin
        ratio_o   = '0;
        illegal_o = 1'b0;
        unique case (mode_i)
            MODE_KERNEL: begin
                ratio_o   = kernel_ratio(code_i);
                illegal_o = !sel_valid_i;
            end
            MODE_BUS_DIV1: begin
                ratio_o   = RATIO_W'(1);
                illegal_o = (bus_psc_i != '0);
            end
            MODE_BUS_DIV2: ratio_o = RATIO_W'(2);
            MODE_BUS_DIV4: ratio_o = RATIO_W'(4);
            default: begin
                ratio_o   = '0;
                illegal_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/conv_tick_divider.sv
module conv_tick_divider
    import conv_clk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               pulse_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        pulse_o = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if ({1'b0, st_q.cnt} == (ratio_i - RATIO_W'(1))) begin
                pulse_o  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/conv_clk_prescaler.sv
module conv_clk_prescaler
    import conv_clk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_tick_i,
    input  logic                 bus_tick_i,
    input  logic [SEL_W-1:0]     src_sel_i,
    input  logic [CODE_W-1:0]    psc_code_i,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic [BUS_PSC_W-1:0] bus_psc_i,
    output logic                 conv_en_o,
    output logic                 cfg_err_o
);

    typedef struct packed {
        conv_cfg_t cfg;
        logic      en;
        logic      err;
    } top_state_t;

    top_state_t st_d, st_q;

    conv_cfg_t          cfg_now;
    logic               cfg_changed;
    logic               sel_valid;
    logic               qual_tick;
    logic [RATIO_W-1:0] ratio;
    logic               illegal;
    logic               div_pulse;

    always_comb begin
        cfg_now.mode = conv_mode_e'(mode_i);
        cfg_now.sel  = src_sel_i;
        cfg_now.code = psc_code_i;
        cfg_changed  = (cfg_now != st_q.cfg);
    end

    conv_tick_select u_sel (
        .src_tick_i  (src_tick_i),
        .bus_tick_i  (bus_tick_i),
        .sel_i       (src_sel_i),
        .mode_i      (cfg_now.mode),
        .tick_o      (qual_tick),
        .sel_valid_o (sel_valid)
    );

    conv_ratio_decode u_dec (
        .mode_i      (cfg_now.mode),
        .code_i      (psc_code_i),
        .sel_valid_i (sel_valid),
        .bus_psc_i   (bus_psc_i),
        .ratio_o     (ratio),
        .illegal_o   (illegal)
    );

    conv_tick_divider u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cfg_changed || illegal),
        .tick_i  (qual_tick),
        .ratio_i (ratio),
        .pulse_o (div_pulse)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_now;
        st_d.en  = div_pulse && !illegal && !cfg_changed;
        st_d.err = illegal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_en_o = st_q.en;
    assign cfg_err_o = st_q.err;

endmodule

// File: rtl/conv_clk_prescaler_chk.sv
module conv_clk_prescaler_chk
    import conv_clk_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   src_tick_i,
    input logic                 bus_tick_i,
    input logic [SEL_W-1:0]     src_sel_i,
    input logic [MODE_W-1:0]    mode_i,
    input logic [BUS_PSC_W-1:0] bus_psc_i,
    input logic                 conv_en_o,
    input logic                 cfg_err_o
);

    // R1: outputs held low while reset is asserted
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!conv_en_o && !cfg_err_o);
        end
    end

    // R2: an enable pulse follows some tick in the preceding cycle
    assert_en_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en_o |-> $past(|src_tick_i || bus_tick_i));

    // R5: missing kernel source is flagged next cycle
    assert_src_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && src_sel_i == 2'd3) |=> cfg_err_o);

    // R7: bus divide-by-1 with a divided bus is flagged next cycle
    assert_bus_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && bus_psc_i != '0) |=> cfg_err_o);

    // R7: no enable while the error flag stands
    assert_err_blocks_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !conv_en_o);

    // R6: legal bus divide-by-1 passes each bus tick once setting is settled
    assert_bus_div1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_i == 2'd1 && bus_psc_i == '0 && bus_tick_i
         && $stable(mode_i)) |=> conv_en_o);

endmodule

bind conv_clk_prescaler conv_clk_prescaler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_tick_i (src_tick_i),
    .bus_tick_i (bus_tick_i),
    .src_sel_i  (src_sel_i),
    .mode_i     (mode_i),
    .bus_psc_i  (bus_psc_i),
    .conv_en_o  (conv_en_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/conv_clk_prescaler_tb.sv
module conv_clk_prescaler_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_tick_i = '0;
    logic       bus_tick_i = 1'b0;
    logic [1:0] src_sel_i = '0;
    logic [3:0] psc_code_i = '0;
    logic [1:0] mode_i = '0;
    logic [2:0] bus_psc_i = '0;
    logic       conv_en_o;
    logic       cfg_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    conv_clk_prescaler u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick_i (src_tick_i),
        .bus_tick_i (bus_tick_i),
        .src_sel_i  (src_sel_i),
        .psc_code_i (psc_code_i),
        .mode_i     (mode_i),
        .bus_psc_i  (bus_psc_i),
        .conv_en_o  (conv_en_o),
        .cfg_err_o  (cfg_err_o)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Apply a setting and wait one idle cycle so the restart cycle passes.
    task automatic set_cfg(input int mode, input int sel, input int code, input int bpsc);
        @(negedge clk);
        mode_i     = 2'(mode);
        src_sel_i  = 2'(sel);
        psc_code_i = 4'(code);
        bus_psc_i  = 3'(bpsc);
        @(negedge clk);
    endtask

    // Pulse the lines in mask ([2:0] kernel sources, [3] bus) n times.
    task automatic pulse(input logic [3:0] mask, input int n, output int cnt, output int first);
        cnt   = 0;
        first = 0;
        for (int i = 1; i <= n; i++) begin
            src_tick_i = mask[2:0];
            bus_tick_i = mask[3];
            @(negedge clk);
            src_tick_i = '0;
            bus_tick_i = 1'b0;
            if (conv_en_o) begin
                cnt++;
                if (first == 0) first = i;
            end
            @(negedge clk);
            if (conv_en_o) cnt += 100;
        end
    endtask

    function automatic int ratio_of(input int code);
        int tbl[12] = '{1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256};
        return (code < 12) ? tbl[code] : 256;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", conv_en_o, 0, "enable in reset");
        check("R1", cfg_err_o, 0, "error in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", conv_en_o, 0, "enable after reset");
        check("R1", cfg_err_o, 0, "error after reset");
    endtask

    task automatic t_kernel_ratios();
        int cnt, first, n;
        for (int code = 0; code < 16; code++) begin
            n = ratio_of(code);
            set_cfg(0, 2, code, 0);
            pulse(4'b0100, 2 * n, cnt, first);
            if (code < 12) begin
                check("R2", cnt, 2, $sformatf("pulses for code %0d", code));
                check("R2", first, n, $sformatf("first pulse tick code %0d", code));
            end else begin
                check("R3", cnt, 2, $sformatf("pulses for code %0d", code));
                check("R3", first, 256, $sformatf("first pulse tick code %0d", code));
            end
        end
    endtask

    task automatic t_source_select();
        int cnt, first;
        for (int s = 0; s < 3; s++) begin
            set_cfg(0, s, 2, 0);
            pulse(4'b1111 & ~(4'b0001 << s), 9, cnt, first);
            check("R4", cnt, 0, $sformatf("pulses from unselected lines, sel %0d", s));
            pulse(4'(1 << s), 4, cnt, first);
            check("R4", first, 4, $sformatf("first pulse from selected sel %0d", s));
        end
    endtask

    task automatic t_bad_source();
        int cnt, first;
        set_cfg(0, 3, 0, 0);
        check("R5", cfg_err_o, 1, "error for source 3");
        pulse(4'b1111, 5, cnt, first);
        check("R5", cnt, 0, "pulses for source 3");
        set_cfg(0, 0, 0, 0);
        check("R9", cfg_err_o, 0, "error cleared after legal source");
    endtask

    task automatic t_bus_modes();
        int cnt, first;
        set_cfg(1, 0, 5, 0);
        pulse(4'b1000, 3, cnt, first);
        check("R6", cnt, 3, "bus /1 pulses");
        set_cfg(2, 0, 0, 0);
        pulse(4'b0111, 6, cnt, first);
        check("R6", cnt, 0, "kernel ticks in bus /2");
        pulse(4'b1000, 4, cnt, first);
        check("R6", cnt, 2, "bus /2 pulses");
        check("R6", first, 2, "bus /2 first pulse");
        set_cfg(3, 1, 0, 5);
        check("R7", cfg_err_o, 0, "no error for bus /4 with divided bus");
        pulse(4'b1000, 8, cnt, first);
        check("R6", cnt, 2, "bus /4 pulses");
        check("R6", first, 4, "bus /4 first pulse");
    endtask

    task automatic t_bus_div1_illegal();
        int cnt, first;
        set_cfg(1, 0, 0, 2);
        check("R7", cfg_err_o, 1, "error for bus /1 with divided bus");
        pulse(4'b1000, 4, cnt, first);
        check("R7", cnt, 0, "pulses while illegal");
        @(negedge clk);
        bus_psc_i = 3'd0;
        @(negedge clk);
        check("R9", cfg_err_o, 0, "error cleared when bus undivided");
        pulse(4'b1000, 3, cnt, first);
        check("R9", cnt, 3, "pulses after error cleared");
    endtask

    task automatic t_restart();
        int cnt, first;
        set_cfg(0, 0, 2, 0);
        pulse(4'b0001, 3, cnt, first);
        check("R8", cnt, 0, "partial count before change");
        set_cfg(0, 0, 3, 0);
        pulse(4'b0001, 6, cnt, first);
        check("R8", first, 6, "first pulse after ratio change");
        pulse(4'b0001, 3, cnt, first);
        bus_psc_i = 3'd4;
        pulse(4'b0001, 3, cnt, first);
        check("R9", first, 3, "bus setting change keeps count");
        @(negedge clk);
        src_tick_i = 3'b001;
        psc_code_i = 4'd2;
        @(negedge clk);
        src_tick_i = '0;
        @(negedge clk);
        check("R8", conv_en_o, 0, "tick in change cycle not counted");
        pulse(4'b0001, 4, cnt, first);
        check("R8", first, 4, "full period after change with tick");
    endtask

    initial begin
        t_reset();
        t_kernel_ratios();
        t_source_select();
        t_bad_source();
        t_bus_modes();
        t_bus_div1_illegal();
        t_restart();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule